// File: doc/BRIEF.md
# Dual-Edge Packet Lane Receiver

This block is the receive side of a packet-oriented memory bus. It has three lanes that run side by side and are framed separately: a narrow row-command lane, a wider column-command lane and a data lane. Every lane carries one transfer on each rising clock edge and one on each falling clock edge. A packet takes four clock cycles, so it holds eight transfers. The block collects those eight transfers and presents them as one parallel word, together with a one-cycle valid flag.

A lane opens a packet when its frame-start input is high at a rising edge. That rising edge also carries the packet's first transfer. A new frame-start that arrives before the open packet is complete raises a one-cycle framing error. The partial packet is dropped, and the new frame-start opens a fresh packet. Transfers seen while no packet is open are ignored. Command decoding, bank handling and electrical signalling are done by other blocks.

Top module: `pkt_lane_rx`

## Requirements
- R1: While reset is asserted and right after it, all valid and framing-error outputs are low and all packet outputs are zero.
- R2: The row packet is 24 bits. Transfer k (k = 0..7, even k sampled on a rising edge, odd k on the following falling edge) occupies bits [23-3k : 21-3k]. The first transfer is in the most significant position.
- R3: The column packet is 40 bits. Transfer k occupies bits [39-5k : 35-5k].
- R4: With the default parameter the data lane is 16 bits wide and its packet is 128 bits, with transfer k in bits [127-16k : 112-16k]. Setting the error-correction parameter widens the lane to 18 bits and the packet to 144 bits.
- R5: A lane's valid output is high for exactly one cycle. It becomes visible after the fourth rising edge that follows the rising edge at which the frame-start was sampled.
- R6: Packets may follow back-to-back, with the next frame-start on the rising edge right after a packet's last falling-edge transfer. Every packet is then delivered, one valid pulse every four cycles.
- R7: A frame-start sampled while a packet is partly collected gives a one-cycle framing-error pulse on that lane one rising edge later. The partial packet is never delivered, and the packet opened by the new frame-start is delivered normally.
- R8: The lanes are independent. Framing activity or errors on one lane do not change the packets, valid pulses or errors of another lane.
- R9: A packet output keeps its value from one valid pulse until the next one.
- R10: Transfers that arrive while no packet is open and no frame-start is present produce no valid pulse and no framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock; both edges carry transfers |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_sof | input | 1 | Row lane frame-start, sampled on rising edges |
| row_d | input | ROW_W (3) | Row lane transfer bits |
| col_sof | input | 1 | Column lane frame-start |
| col_d | input | COL_W (5) | Column lane transfer bits |
| dat_sof | input | 1 | Data lane frame-start |
| dat_d | input | DAT_W (16 or 18) | Data lane transfer bits |
| row_pkt | output | 2*CYCLES*ROW_W (24) | Assembled row packet |
| row_vld | output | 1 | Row packet valid pulse |
| row_ferr | output | 1 | Row lane framing error pulse |
| col_pkt | output | 2*CYCLES*COL_W (40) | Assembled column packet |
| col_vld | output | 1 | Column packet valid pulse |
| col_ferr | output | 1 | Column lane framing error pulse |
| dat_pkt | output | 2*CYCLES*DAT_W (128 or 144) | Assembled data packet |
| dat_vld | output | 1 | Data packet valid pulse |
| dat_ferr | output | 1 | Data lane framing error pulse |

## Verification
The only state that can go wrong is a lane's beat counter, its shift register and its falling-edge capture. A slipped counter shows up within one packet: the valid pulse arrives a cycle early or late against the expected cycle, and back-to-back traffic then either drops a packet or raises a false framing error. A wrong half-cycle capture, or a wrong shift order, swaps or misplaces transfer fields in the very first packet. The directed scenarios use known bit patterns as well as random packets on all three lanes at once, so each of these faults shows up within about four cycles of the first frame-start.

// File: rtl/pkt_lane_pkg.sv
package pkt_lane_pkg;
   localparam int unsigned DEF_ROW_W  = 3;
   localparam int unsigned DEF_COL_W  = 5;
   localparam int unsigned BASE_DAT_W = 16;
   localparam int unsigned ECC_DAT_W  = 18;
   localparam int unsigned DEF_CYCLES = 4;

   function automatic int unsigned pkt_bits(input int unsigned lane_w, input int unsigned cycles);
      return 2 * lane_w * cycles;
   endfunction
endpackage

// File: rtl/pkt_edge_capture.sv
module pkt_edge_capture #(
   parameter int unsigned W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sof_i,
   input  logic [W-1:0] d_i,
   output logic         sof_q,
   output logic [W-1:0] rise_q,
   output logic [W-1:0] fall_q
);
   logic [W-1:0] fall_hold;

   // rising-edge sample: frame-start plus even transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sof_q  <= 1'b0;
         rise_q <= '0;
      end else begin
         sof_q  <= sof_i;
         rise_q <= d_i;
      end
   end

   // falling-edge sample: odd transfer
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) fall_hold <= '0;
      else        fall_hold <= d_i;
   end

   assign fall_q = fall_hold;
endmodule

// File: rtl/pkt_assembler.sv
module pkt_assembler #(
   parameter int unsigned W      = 3,
   parameter int unsigned CYCLES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sof_q,
   input  logic [W-1:0]             rise_q,
   input  logic [W-1:0]             fall_q,
   output logic [2*W*CYCLES-1:0]    pkt_o,
   output logic                     vld_o,
   output logic                     ferr_o
);
   localparam int unsigned PAIR_W = 2 * W;
   localparam int unsigned PKT_W  = PAIR_W * CYCLES;
   localparam int unsigned CNT_W  = $clog2(CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

   if (CYCLES < 2) begin : g_bad_cycles
      $error("pkt_assembler: CYCLES must be at least 2");
   end

   logic [PAIR_W-1:0] pair;
   logic [CNT_W-1:0]  cnt;
   logic [PKT_W-1:0]  acc;

   assign pair = {rise_q, fall_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         acc    <= '0;
         pkt_o  <= '0;
         vld_o  <= 1'b0;
         ferr_o <= 1'b0;
      end else begin
         vld_o  <= 1'b0;
         ferr_o <= 1'b0;
         if (sof_q) begin
            ferr_o <= (cnt != '0);
            acc    <= PKT_W'(pair);
            cnt    <= CNT_W'(1);
         end else if (cnt != '0) begin
            if (cnt == LAST) begin
               pkt_o <= {acc[PKT_W-PAIR_W-1:0], pair};
               vld_o <= 1'b1;
               cnt   <= '0;
            end else begin
               acc <= {acc[PKT_W-PAIR_W-1:0], pair};
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

   p_vld_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |=> !vld_o)
      else $error("valid held longer than one cycle");

   p_vld_on_last_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> ($past(cnt) == LAST && !$past(sof_q)))
      else $error("valid without a full packet");

   p_pkt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_o |-> $stable(pkt_o))
      else $error("packet changed without valid");

   p_err_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ferr_o |-> (!vld_o && $past(sof_q)))
      else $error("framing error without a frame-start");

   p_err_mid_packet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_q && cnt != '0) |=> ferr_o)
      else $error("mid-packet frame-start not flagged");
endmodule

// File: rtl/pkt_lane.sv
module pkt_lane #(
   parameter int unsigned W      = 3,
   parameter int unsigned CYCLES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sof_i,
   input  logic [W-1:0]          d_i,
   output logic [2*W*CYCLES-1:0] pkt_o,
   output logic                  vld_o,
   output logic                  ferr_o
);
   logic         sof_q;
   logic [W-1:0] rise_q;
   logic [W-1:0] fall_q;

   pkt_edge_capture #(.W(W)) u_cap (
      .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .d_i(d_i),
      .sof_q(sof_q), .rise_q(rise_q), .fall_q(fall_q)
   );

   pkt_assembler #(.W(W), .CYCLES(CYCLES)) u_asm (
      .clk(clk), .rst_n(rst_n), .sof_q(sof_q), .rise_q(rise_q), .fall_q(fall_q),
      .pkt_o(pkt_o), .vld_o(vld_o), .ferr_o(ferr_o)
   );
endmodule

// File: rtl/pkt_lane_rx.sv
module pkt_lane_rx
   import pkt_lane_pkg::*;
#(
   parameter int unsigned ROW_W  = DEF_ROW_W,
   parameter int unsigned COL_W  = DEF_COL_W,
   parameter bit          ECC_EN = 1'b0,
   parameter int unsigned CYCLES = DEF_CYCLES,
   parameter int unsigned DAT_W  = ECC_EN ? ECC_DAT_W : BASE_DAT_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      row_sof,
   input  logic [ROW_W-1:0]          row_d,
   input  logic                      col_sof,
   input  logic [COL_W-1:0]          col_d,
   input  logic                      dat_sof,
   input  logic [DAT_W-1:0]          dat_d,
   output logic [2*CYCLES*ROW_W-1:0] row_pkt,
   output logic                      row_vld,
   output logic                      row_ferr,
   output logic [2*CYCLES*COL_W-1:0] col_pkt,
   output logic                      col_vld,
   output logic                      col_ferr,
   output logic [2*CYCLES*DAT_W-1:0] dat_pkt,
   output logic                      dat_vld,
   output logic                      dat_ferr
);
   localparam int unsigned ROW_PKT = pkt_bits(ROW_W, CYCLES);
   localparam int unsigned DAT_PKT = pkt_bits(DAT_W, CYCLES);

   if (ROW_W == 0 || COL_W == 0) begin : g_bad_cmd_w
      $error("pkt_lane_rx: command lanes need a nonzero width");
   end
   if (DAT_W != (ECC_EN ? ECC_DAT_W : BASE_DAT_W)) begin : g_bad_dat_w
      $error("pkt_lane_rx: data width does not match the error-correction setting");
   end
   if (ROW_PKT != 2 * CYCLES * ROW_W || DAT_PKT != 2 * CYCLES * DAT_W) begin : g_bad_pkt
      $error("pkt_lane_rx: packet width mismatch");
   end

   pkt_lane #(.W(ROW_W), .CYCLES(CYCLES)) u_row (
      .clk(clk), .rst_n(rst_n), .sof_i(row_sof), .d_i(row_d),
      .pkt_o(row_pkt), .vld_o(row_vld), .ferr_o(row_ferr)
   );

   pkt_lane #(.W(COL_W), .CYCLES(CYCLES)) u_col (
      .clk(clk), .rst_n(rst_n), .sof_i(col_sof), .d_i(col_d),
      .pkt_o(col_pkt), .vld_o(col_vld), .ferr_o(col_ferr)
   );

   pkt_lane #(.W(DAT_W), .CYCLES(CYCLES)) u_dat (
      .clk(clk), .rst_n(rst_n), .sof_i(dat_sof), .d_i(dat_d),
      .pkt_o(dat_pkt), .vld_o(dat_vld), .ferr_o(dat_ferr)
   );

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> !(row_vld || col_vld || dat_vld || row_ferr || col_ferr || dat_ferr))
      else $error("outputs active in reset");
endmodule

// File: tb/pkt_lane_rx_bench.sv
module pkt_lane_rx_bench;
   localparam int NC = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic         row_sof = 0, col_sof = 0, dat_sof = 0;
   logic [2:0]   row_d = 0;
   logic [4:0]   col_d = 0;
   logic [15:0]  dat_d = 0;
   logic [23:0]  row_pkt;
   logic [39:0]  col_pkt;
   logic [127:0] dat_pkt;
   logic         row_vld, col_vld, dat_vld, row_ferr, col_ferr, dat_ferr;

   pkt_lane_rx u_pkt_lane_rx (
      .clk(clk), .rst_n(rst_n),
      .row_sof(row_sof), .row_d(row_d), .col_sof(col_sof), .col_d(col_d),
      .dat_sof(dat_sof), .dat_d(dat_d),
      .row_pkt(row_pkt), .row_vld(row_vld), .row_ferr(row_ferr),
      .col_pkt(col_pkt), .col_vld(col_vld), .col_ferr(col_ferr),
      .dat_pkt(dat_pkt), .dat_vld(dat_vld), .dat_ferr(dat_ferr)
   );

   typedef struct { logic [127:0] p; int c; } exp_t;

   int tests = 0, fails = 0, cyc = 0;
   bit done = 0;
   exp_t qr[$], qc[$], qd[$];
   int nerr[3];

   logic          s_sof[3][NC];
   logic [15:0]   s_ev[3][NC];
   logic [15:0]   s_od[3][NC];
   logic          s_psh[3][NC];
   logic [127:0]  s_ex[3][NC];

   function automatic int lw(input int l);
      return (l == 0) ? 3 : (l == 1) ? 5 : 16;
   endfunction

   function automatic logic [15:0] xfer(input int l, input logic [127:0] p, input int k);
      logic [127:0] t;
      t = p >> ((7 - k) * lw(l));
      return t[15:0] & ((16'h1 << lw(l)) - 16'h1);
   endfunction

   function automatic logic [127:0] rnd_pkt(input int l);
      logic [127:0] r;
      r = {$urandom, $urandom, $urandom, $urandom};
      if (l != 2) r = r & ((128'h1 << (8 * lw(l))) - 128'h1);
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_sched();
      for (int l = 0; l < 3; l++)
         for (int c = 0; c < NC; c++) begin
            s_sof[l][c] = 0; s_psh[l][c] = 0; s_ex[l][c] = '0;
            s_ev[l][c] = 16'($urandom); s_od[l][c] = 16'($urandom);
         end
      nerr = '{0, 0, 0};
   endtask

   // place a packet; 'full' = 0 places only 'beats' cycles of it and expects nothing
   task automatic put(input int l, input int st, input logic [127:0] p, input bit full, input int beats);
      s_sof[l][st] = 1;
      s_psh[l][st] = full;
      s_ex[l][st]  = p;
      for (int j = 0; j < beats; j++) begin
         s_ev[l][st + j] = xfer(l, p, 2 * j);
         s_od[l][st + j] = xfer(l, p, 2 * j + 1);
      end
   endtask

   task automatic run_sched(input int n);
      for (int c = 0; c < n + 6; c++) begin
         @(negedge clk); #5;
         row_sof = (c < n) ? s_sof[0][c] : 1'b0;
         col_sof = (c < n) ? s_sof[1][c] : 1'b0;
         dat_sof = (c < n) ? s_sof[2][c] : 1'b0;
         row_d = (c < n) ? s_ev[0][c][2:0] : 3'($urandom);
         col_d = (c < n) ? s_ev[1][c][4:0] : 5'($urandom);
         dat_d = (c < n) ? s_ev[2][c]      : 16'($urandom);
         if (c < n) begin
            if (s_psh[0][c]) qr.push_back('{s_ex[0][c], cyc + 5});
            if (s_psh[1][c]) qc.push_back('{s_ex[1][c], cyc + 5});
            if (s_psh[2][c]) qd.push_back('{s_ex[2][c], cyc + 5});
         end
         @(posedge clk); #5;
         row_sof = 0; col_sof = 0; dat_sof = 0;
         row_d = (c < n) ? s_od[0][c][2:0] : 3'($urandom);
         col_d = (c < n) ? s_od[1][c][4:0] : 5'($urandom);
         dat_d = (c < n) ? s_od[2][c]      : 16'($urandom);
      end
   endtask

   task automatic drained(input string req);
      check(qr.size() == 0, {req, " row packets delivered"}, 128'(qr.size()), 0);
      check(qc.size() == 0, {req, " col packets delivered"}, 128'(qc.size()), 0);
      check(qd.size() == 0, {req, " data packets delivered"}, 128'(qd.size()), 0);
      qr.delete(); qc.delete(); qd.delete();
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   task automatic mon(input int l, input logic v, input logic [127:0] p);
      exp_t e;
      string tag;
      tag = (l == 0) ? "R2" : (l == 1) ? "R3" : "R4";
      if (!v) return;
      if (l == 0 && qr.size() != 0) e = qr.pop_front();
      else if (l == 1 && qc.size() != 0) e = qc.pop_front();
      else if (l == 2 && qd.size() != 0) e = qd.pop_front();
      else begin
         check(0, "R10 unexpected valid", p, 0);
         return;
      end
      check(p == e.p, tag, p, e.p);
      check(cyc == e.c, "R5 valid cycle", 128'(cyc), 128'(e.c));
   endtask

   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         mon(0, row_vld, 128'(row_pkt));
         mon(1, col_vld, 128'(col_pkt));
         mon(2, dat_vld, dat_pkt);
         if (row_ferr) nerr[0]++;
         if (col_ferr) nerr[1]++;
         if (dat_ferr) nerr[2]++;
      end
   end

   task automatic t_reset();
      check({row_vld, col_vld, dat_vld, row_ferr, col_ferr, dat_ferr} == 0, "R1 flags in reset",
            {row_vld, col_vld, dat_vld, row_ferr, col_ferr, dat_ferr}, 0);
      check(row_pkt == 0 && col_pkt == 0 && dat_pkt == 0, "R1 packets in reset", dat_pkt, 0);
   endtask

   task automatic t_known_order();
      clear_sched();
      put(0, 1, 128'o01234567, 1, 4);           // R2 transfer k carries value k
      put(1, 2, 128'h0_8864_2988, 1, 4);        // R3 fixed pattern
      put(2, 0, 128'h0000_1111_2222_3333_4444_5555_6666_7777, 1, 4); // R4
      run_sched(8);
      drained("R2 R3 R4");
      check(row_pkt == 24'o01234567, "R2 field order", 128'(row_pkt), 128'o01234567);
      check(dat_pkt[127:112] == 16'h0000 && dat_pkt[15:0] == 16'h7777, "R4 field order",
            dat_pkt, 128'h0000_1111_2222_3333_4444_5555_6666_7777);
   endtask

   task automatic t_back_to_back();
      clear_sched();
      for (int k = 0; k < 6; k++) begin
         put(0, 4 * k, rnd_pkt(0), 1, 4);
         put(1, 4 * k + 1, rnd_pkt(1), 1, 4);
         put(2, 4 * k + 2, rnd_pkt(2), 1, 4);
      end
      run_sched(28);
      drained("R6");
      check(nerr[0] + nerr[1] + nerr[2] == 0, "R6 no framing error", 128'(nerr[0] + nerr[1] + nerr[2]), 0);
   endtask

   task automatic t_frame_error();
      clear_sched();
      put(0, 0, rnd_pkt(0), 0, 2);   // partial row packet, cut by next frame-start
      put(0, 2, rnd_pkt(0), 1, 4);
      put(1, 0, rnd_pkt(1), 1, 4);   // R8 neighbours run normally
      put(1, 4, rnd_pkt(1), 1, 4);
      put(2, 1, rnd_pkt(2), 0, 3);   // partial data packet cut at its last beat
      put(2, 4, rnd_pkt(2), 1, 4);
      run_sched(10);
      drained("R7");
      check(nerr[0] == 1, "R7 row framing error", 128'(nerr[0]), 1);
      check(nerr[2] == 1, "R7 data framing error", 128'(nerr[2]), 1);
      check(nerr[1] == 0, "R8 column lane untouched", 128'(nerr[1]), 0);
   endtask

   task automatic t_idle_noise();
      logic [23:0] r0;
      logic [39:0] c0;
      logic [127:0] d0;
      r0 = row_pkt; c0 = col_pkt; d0 = dat_pkt;
      clear_sched();                 // random transfers, no frame-start
      run_sched(12);
      drained("R10");
      check(nerr[0] + nerr[1] + nerr[2] == 0, "R10 no error on idle", 128'(nerr[0] + nerr[1] + nerr[2]), 0);
      check(row_pkt == r0 && col_pkt == c0 && dat_pkt == d0, "R9 packets held", dat_pkt, d0);
   endtask

   task automatic finish_run();
      if (done) return;
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #2000000;
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      t_reset();
      rst_n = 1;
      repeat (2) @(posedge clk);
      #5;
      t_reset();
      t_known_order();
      t_back_to_back();
      t_frame_error();
      t_idle_noise();
      finish_run();
   end
endmodule